// File: doc/BRIEF.md
# Five-Symbol Morse Digit Decoder

This block turns a five-symbol Morse pattern, presented in parallel, into one BCD digit. Each input bit is a single symbol: a 1 is a dash and a 0 is a dot. Bit 4 is the first symbol sent, which is the leftmost one.

A valid digit is a run of one symbol type followed by a run of the other type. A leading run of dots encodes a digit from 1 to 5. A leading run of dashes encodes 6 to 9, or 0 when every symbol is a dash. Every other pattern raises an error flag, and the digit output is then forced to zero.

The decoding logic has no state. Its result is captured in an output register that has a synchronous reset, so a decoded digit appears one clock after the pattern is applied.

Top module: `morse_digit_decoder`

## Requirements
- R1: Patterns made of dots followed by dashes give digits 1 to 4: 5'b01111 gives 1, 5'b00111 gives 2, 5'b00011 gives 3 and 5'b00001 gives 4 (bit 4 is the first symbol, 1 is a dash).
- R2: The all-dot pattern 5'b00000 gives digit 5.
- R3: The all-dash pattern 5'b11111 gives digit 0.
- R4: Patterns made of dashes followed by dots give digits 6 to 9: 5'b10000 gives 6, 5'b11000 gives 7, 5'b11100 gives 8 and 5'b11110 gives 9.
- R5: The error flag is 1 for each of the 22 patterns that are not among the ten codes above.
- R6: When the error flag is 1, the digit output is 4'b0000.
- R7: The error flag is 0 for each of the ten valid codes, and the digit output never exceeds 9.
- R8: Outputs are registered. A pattern applied before a rising clock edge shows on the outputs after that edge, and the outputs do not change before it.
- R9: While rst is high at a rising edge, the outputs become digit 0 with the error flag 0, whatever the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_code | input | 5 | Morse pattern; bit 4 is the first symbol, 1 means dash |
| bcd_digit | output | 4 | Decoded BCD digit, bit 3 is the MSB |
| code_err | output | 1 | High when the pattern is not a valid digit |

## Verification
Every result is due exactly one rising edge after its input. The bench changes `sym_code` on a falling edge, waits for one rising edge, and samples on the following falling edge. The latency scenario also samples before that rising edge, to show that the outputs still hold the previous value. All 32 patterns are checked against a ten-entry table of valid codes that the bench keeps itself, and a reset is applied in the middle of a run to check that it takes effect on the edge.

// File: rtl/morse_dec_pkg.sv
package morse_dec_pkg;
  localparam int SYM_W = 5;
  localparam int DIG_W = 4;

  typedef struct packed {
    logic             bad;
    logic [DIG_W-1:0] digit;
  } dec_res_t;
endpackage

// File: rtl/morse_run_scan.sv
module morse_run_scan #(
  parameter int SYM_W = 5,
  parameter int RUN_W = $clog2(SYM_W + 1)
) (
  input  logic [SYM_W-1:0] code,
  output logic             lead_sym,
  output logic [RUN_W-1:0] run_len,
  output logic             tail_ok
);
  // in_run[i] is high while bit i still belongs to the leading run
  logic [SYM_W-1:0] in_run;

  assign lead_sym          = code[SYM_W-1];
  assign in_run[SYM_W-1]   = 1'b1;

  genvar gi;
  generate
    for (gi = SYM_W - 2; gi >= 0; gi--) begin : g_chain
      assign in_run[gi] = in_run[gi+1] & (code[gi] == lead_sym);
    end
  endgenerate

  always_comb begin
    run_len = '0;
    for (int i = 0; i < SYM_W; i++) begin
      run_len = run_len + RUN_W'(in_run[i]);
    end
  end

  // every bit outside the run must be the opposite symbol
  assign tail_ok = &(in_run | (code ^ {SYM_W{lead_sym}}));
endmodule

// File: rtl/morse_digit_map.sv
module morse_digit_map
  import morse_dec_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int RUN_W = $clog2(SYM_W + 1)
) (
  input  logic             lead_sym,
  input  logic [RUN_W-1:0] run_len,
  input  logic             tail_ok,
  output dec_res_t         res
);
  localparam logic [RUN_W-1:0] FULL_RUN = RUN_W'(SYM_W);
  localparam logic [DIG_W-1:0] DASH_OFS = DIG_W'(SYM_W);

  always_comb begin
    res = '0;
    if (run_len == FULL_RUN) begin
      res.digit = lead_sym ? '0 : DASH_OFS;
    end else if (!tail_ok) begin
      res.bad = 1'b1;
    end else if (lead_sym) begin
      res.digit = DIG_W'(run_len) + DASH_OFS;
    end else begin
      res.digit = DIG_W'(run_len);
    end
  end
endmodule

// File: rtl/morse_digit_decoder.sv
module morse_digit_decoder
  import morse_dec_pkg::*;
#(
  parameter int CODE_W = SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sym_code,
  output logic [DIG_W-1:0]  bcd_digit,
  output logic              code_err
);
  localparam int RUN_W = $clog2(CODE_W + 1);

  logic             lead_sym;
  logic [RUN_W-1:0] run_len;
  logic             tail_ok;
  dec_res_t         nxt;

  morse_run_scan #(.SYM_W(CODE_W), .RUN_W(RUN_W)) u_scan (
    .code    (sym_code),
    .lead_sym(lead_sym),
    .run_len (run_len),
    .tail_ok (tail_ok)
  );

  morse_digit_map #(.SYM_W(CODE_W), .RUN_W(RUN_W)) u_map (
    .lead_sym(lead_sym),
    .run_len (run_len),
    .tail_ok (tail_ok),
    .res     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_digit <= '0;
      code_err  <= 1'b0;
    end else begin
      bcd_digit <= nxt.digit;
      code_err  <= nxt.bad;
    end
  end

  AST_ALL_DASH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sym_code == 5'b11111) |=> (bcd_digit == 4'd0 && !code_err)); // R3
  AST_ALL_DOT_FIVE: assert property (@(posedge clk) disable iff (rst)
    (sym_code == 5'b00000) |=> (bcd_digit == 4'd5 && !code_err)); // R2
  AST_DASH_RUN_NINE: assert property (@(posedge clk) disable iff (rst)
    (sym_code == 5'b11110) |=> (bcd_digit == 4'd9 && !code_err)); // R4
  AST_DOT_RUN_ONE: assert property (@(posedge clk) disable iff (rst)
    (sym_code == 5'b01111) |=> (bcd_digit == 4'd1 && !code_err)); // R1
  AST_MIXED_IS_ERR: assert property (@(posedge clk) disable iff (rst)
    (sym_code == 5'b10101) |=> code_err); // R5
  AST_ERR_ZERO_DIGIT: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (bcd_digit == 4'd0)); // R6
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (bcd_digit <= 4'd9)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (bcd_digit == 4'd0 && !code_err)); // R9
endmodule

// File: tb/tb_morse_digit_decoder.sv
module tb_morse_digit_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] sym_code = 5'b0;
  logic [3:0] bcd_digit;
  logic       code_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  morse_digit_decoder dut (
    .clk      (clk),
    .rst      (rst),
    .sym_code (sym_code),
    .bcd_digit(bcd_digit),
    .code_err (code_err)
  );

  // expected result from the ten-entry code table of the requirements
  function automatic void ref_dec(input logic [4:0] c, output logic [3:0] d,
                                  output logic e);
    e = 1'b0;
    case (c)
      5'b11111: d = 4'd0;
      5'b01111: d = 4'd1;
      5'b00111: d = 4'd2;
      5'b00011: d = 4'd3;
      5'b00001: d = 4'd4;
      5'b00000: d = 4'd5;
      5'b10000: d = 4'd6;
      5'b11000: d = 4'd7;
      5'b11100: d = 4'd8;
      5'b11110: d = 4'd9;
      default: begin d = 4'd0; e = 1'b1; end
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp_d, input logic exp_e);
    n_chk++;
    if (bcd_digit !== exp_d || code_err !== exp_e) begin
      n_fail++;
      $display("FAIL %s: code=%b digit=%0d err=%b expected digit=%0d err=%b",
               req, sym_code, bcd_digit, code_err, exp_d, exp_e);
    end
  endtask

  task automatic apply(input logic [4:0] c);
    @(negedge clk);
    sym_code = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    sym_code = 5'b10101;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 reset state", 4'd0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_named_codes();
    logic [3:0] d; logic e;
    apply(5'b01111); check("R1 code 01111", 4'd1, 1'b0);
    apply(5'b00111); check("R1 code 00111", 4'd2, 1'b0);
    apply(5'b00011); check("R1 code 00011", 4'd3, 1'b0);
    apply(5'b00001); check("R1 code 00001", 4'd4, 1'b0);
    apply(5'b00000); check("R2 all dots", 4'd5, 1'b0);
    apply(5'b11111); check("R3 all dashes", 4'd0, 1'b0);
    apply(5'b10000); check("R4 code 10000", 4'd6, 1'b0);
    apply(5'b11000); check("R4 code 11000", 4'd7, 1'b0);
    apply(5'b11100); check("R4 code 11100", 4'd8, 1'b0);
    apply(5'b11110); check("R4 code 11110", 4'd9, 1'b0);
    ref_dec(5'b01010, d, e);
    apply(5'b01010); check("R5 R6 code 01010", d, e);
  endtask

  task automatic t_exhaustive();
    int n_err = 0;
    for (int i = 0; i < 32; i++) begin
      logic [3:0] d; logic e;
      ref_dec(5'(i), d, e);
      apply(5'(i));
      if (e) begin
        n_err++;
        check("R5 R6 invalid pattern", d, e);
      end else begin
        check("R7 valid pattern", d, e);
      end
    end
    n_chk++;
    if (n_err != 22) begin
      n_fail++;
      $display("FAIL R5: invalid count actual=%0d expected=22", n_err);
    end
  endtask

  task automatic t_latency();
    apply(5'b11100);
    @(negedge clk);
    sym_code = 5'b00011;
    #1;
    check("R8 held before edge", 4'd8, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R8 updated after edge", 4'd3, 1'b0);
    sym_code = 5'b11011;
    #1;
    check("R8 held before edge err", 4'd3, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R8 updated to err", 4'd0, 1'b1);
  endtask

  task automatic t_reset_mid();
    apply(5'b11110);
    check("R4 before reset", 4'd9, 1'b0);
    t_reset_state();
    apply(5'b11001);
    check("R5 after reset", 4'd0, 1'b1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset_state();
    t_named_codes();
    t_exhaustive();
    t_latency();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule